// File: doc/BRIEF.md
# Sequential Acceptance Filter and Object Store

This block sits between a CAN frame deserialiser and the message-object RAM of a CAN controller. A received frame header arrives on a valid/ready stream: the 29-bit identifier, the extended-format flag, the remote-request flag, the length code and the eight data bytes. Once the block accepts a header, it walks the message objects in RAM from index 0 upwards, one object at a time. It compares each valid object against the header under that object's own filter rules. At the first object that qualifies, it writes the updated object back and stops. If no object qualifies, it reports a miss after the last object.

A qualifying data frame is stored in full, with new-data, lost-message, interrupt-pending and transmit-request bookkeeping applied. A qualifying remote frame takes one of three actions, chosen by the object's direction, auto-reply and mask-enable bits. Each scan ends with a one-cycle result pulse. The pulse carries hit or miss, the object index and the updated flags.

Back-pressure: `hdr_ready` is high only while no scan is running. A header is taken in the cycle where `hdr_valid` and `hdr_ready` are both high. The header fields, data included, must be stable in that cycle. The upstream source holds its header until it is taken. The result pulse has no ready and cannot be stalled.

Top module: `acf_filter`

## Requirements
- R1: `hdr_ready` is 1 when idle, falls in the cycle after a header is accepted, stays 0 throughout the scan, and is 1 again in the cycle that `res_valid` pulses.
- R2: Each RAM word is one packed object, MSB first: valid, mask-enable, direction, auto-reply, rx-interrupt-enable, new-data, lost, int-pending, tx-request, extended, mask-extended, id[28:0], mask[28:0], dlc[3:0], data[63:0]. Reads have one cycle of latency. A read and a write never share a cycle.
- R3: Objects are read in ascending index order, one read every two cycles. `res_valid` pulses 2*(k+1) cycles after the acceptance edge when the scan stops at object k, and 2*NUM_OBJ cycles after it on a miss.
- R4: The lowest-indexed qualifying object wins and later objects are not touched. An object whose valid bit is 0 never qualifies.
- R5: With mask-enable 0, every compared id bit and the extended flag must be equal. With mask-enable 1, id bits whose mask bit is 0 are ignored, and the extended flag is ignored when mask-extended is 0. The direction bit must always equal the received remote flag.
- R6: For a standard-format frame only id[28:18] are compared, and a store writes id[17:0] as 0.
- R7: A data-frame hit stores id, extended flag, dlc and all 8 data bytes, even under masking. It sets new-data to 1 and tx-request to 0, and sets int-pending if rx-interrupt-enable is 1. All other fields are unchanged.
- R8: Lost is set when a data frame is stored while new-data is already 1. Lost is never cleared by the block.
- R9: A remote frame hitting an object with direction 1 and auto-reply 1 sets only tx-request to 1.
- R10: An object with direction 1, auto-reply 0 and mask-enable 0 never qualifies for a remote frame. It is left unchanged and the scan continues.
- R11: A remote frame hitting an object with direction 1, auto-reply 0 and mask-enable 1 stores id, extended flag and dlc, sets new-data to 1, clears tx-request and keeps the data bytes.
- R12: On a hit, `res_obj` and the four `res_*` flags show the object index and its written flags. On a miss, `res_hit`, `res_obj` and all flags are 0 and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header beat offered |
| hdr_ready | output | 1 | Block idle, header can be taken |
| hdr_id | input | 29 | Received identifier (standard ids in [28:18]) |
| hdr_ide | input | 1 | 1 = extended-format frame |
| hdr_rtr | input | 1 | 1 = remote frame |
| hdr_dlc | input | 4 | Received length code |
| hdr_data | input | 64 | Received data bytes |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_addr | output | AW | Object index for read or write |
| ram_wdata | output | OBJ_W | Updated object word |
| ram_rdata | input | OBJ_W | Object word, valid the cycle after a read |
| res_valid | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | 1 = an object qualified |
| res_obj | output | AW | Index of the written object |
| res_newdat | output | 1 | Written new-data flag |
| res_msglst | output | 1 | Written lost flag |
| res_intpnd | output | 1 | Written int-pending flag |
| res_txrqst | output | 1 | Written tx-request flag |

## Verification
A scan index that skips or stalls appears at the ports as a wrong result latency and a wrong `res_obj`. That shows within 2*NUM_OBJ cycles of the header handshake. A wrong compare shows in the same pulse as a hit on the wrong object or a false miss. A wrong update rule shows on `ram_wdata` in the write cycle. It remains readable in the bench's RAM model and in the result flags one cycle later, so corrupted fields, cleared lost flags and wrongly kept data bytes are caught before the next header.

// File: rtl/acf_pkg.sv
package acf_pkg;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic              msgval;
    logic              umask;
    logic              dir;
    logic              rmten;
    logic              rxie;
    logic              newdat;
    logic              msglst;
    logic              intpnd;
    logic              txrqst;
    logic              xtd;
    logic              mxtd;
    logic [ID_W-1:0]   id;
    logic [ID_W-1:0]   msk;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } obj_t;

  localparam int OBJ_W = $bits(obj_t);

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ide;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } hdr_t;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_CMP} scan_st_t;
endpackage

// File: rtl/acf_eval.sv
module acf_eval
  import acf_pkg::*;
(
  input  obj_t obj,
  input  hdr_t hdr,
  output logic hit,
  output obj_t nxt
);
  localparam int EXT_W = ID_W - STD_W;

  logic [ID_W-1:0] care;
  logic [ID_W-1:0] diff;
  logic [ID_W-1:0] store_id;
  logic id_ok, ide_ok, dir_ok, rmt_blocked;

  // filter decision
  always_comb begin
    care = obj.umask ? obj.msk : '1;
    if (!hdr.ide) care[EXT_W-1:0] = '0;
    diff        = (hdr.id ^ obj.id) & care;
    id_ok       = (diff == '0);
    ide_ok      = (obj.umask && !obj.mxtd) || (hdr.ide == obj.xtd);
    dir_ok      = (obj.dir == hdr.rtr);
    rmt_blocked = hdr.rtr && !obj.rmten && !obj.umask;
    hit         = obj.msgval && id_ok && ide_ok && dir_ok && !rmt_blocked;
  end

  // object update for the three hit kinds
  always_comb begin
    store_id = hdr.ide ? hdr.id : {hdr.id[ID_W-1 -: STD_W], {EXT_W{1'b0}}};
    nxt = obj;
    if (!hdr.rtr) begin
      nxt.id     = store_id;
      nxt.xtd    = hdr.ide;
      nxt.dlc    = hdr.dlc;
      nxt.data   = hdr.data;
      nxt.msglst = obj.msglst | obj.newdat;
      nxt.newdat = 1'b1;
      nxt.txrqst = 1'b0;
      nxt.intpnd = obj.intpnd | obj.rxie;
    end else if (obj.rmten) begin
      nxt.txrqst = 1'b1;
    end else begin
      nxt.id     = store_id;
      nxt.xtd    = hdr.ide;
      nxt.dlc    = hdr.dlc;
      nxt.newdat = 1'b1;
      nxt.txrqst = 1'b0;
    end
  end
endmodule

// File: rtl/acf_scan_ctrl.sv
module acf_scan_ctrl
  import acf_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int AW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          hit,
  output logic          idle,
  output logic          rd_en,
  output logic          wr_en,
  output logic          decide,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(NUM_OBJ - 1);

  scan_st_t st;
  logic     at_last;

  assign at_last = (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      idx <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st  <= S_READ;
          idx <= '0;
        end
        S_READ: st <= S_CMP;
        S_CMP: if (hit || at_last) begin
          st <= S_IDLE;
        end else begin
          idx <= idx + 1'b1;
          st  <= S_READ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign idle   = (st == S_IDLE);
  assign rd_en  = (st == S_READ);
  assign wr_en  = (st == S_CMP) && hit;
  assign decide = (st == S_CMP) && (hit || at_last);
endmodule

// File: rtl/acf_filter.sv
module acf_filter
  import acf_pkg::*;
#(
  parameter  int NUM_OBJ = 32,
  localparam int AW      = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hdr_valid,
  output logic                hdr_ready,
  input  logic [ID_W-1:0]     hdr_id,
  input  logic                hdr_ide,
  input  logic                hdr_rtr,
  input  logic [DLC_W-1:0]    hdr_dlc,
  input  logic [DATA_W-1:0]   hdr_data,
  output logic                ram_rd_en,
  output logic                ram_wr_en,
  output logic [AW-1:0]       ram_addr,
  output logic [OBJ_W-1:0]    ram_wdata,
  input  logic [OBJ_W-1:0]    ram_rdata,
  output logic                res_valid,
  output logic                res_hit,
  output logic [AW-1:0]       res_obj,
  output logic                res_newdat,
  output logic                res_msglst,
  output logic                res_intpnd,
  output logic                res_txrqst
);
  hdr_t hdr_q;
  obj_t obj_rd, obj_nxt;
  logic hit, idle, start, decide;

  assign obj_rd    = obj_t'(ram_rdata);
  assign start     = hdr_valid && idle;
  assign hdr_ready = idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_q <= '0;
    else if (start) hdr_q <= '{id: hdr_id, ide: hdr_ide, rtr: hdr_rtr,
                               dlc: hdr_dlc, data: hdr_data};
  end

  acf_scan_ctrl #(.NUM_OBJ(NUM_OBJ), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .hit(hit),
    .idle(idle), .rd_en(ram_rd_en), .wr_en(ram_wr_en),
    .decide(decide), .idx(ram_addr)
  );

  acf_eval u_eval (.obj(obj_rd), .hdr(hdr_q), .hit(hit), .nxt(obj_nxt));

  assign ram_wdata = obj_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_obj    <= '0;
      res_newdat <= 1'b0;
      res_msglst <= 1'b0;
      res_intpnd <= 1'b0;
      res_txrqst <= 1'b0;
    end else begin
      res_valid <= decide;
      if (decide) begin
        res_hit    <= ram_wr_en;
        res_obj    <= ram_wr_en ? ram_addr : '0;
        res_newdat <= ram_wr_en && obj_nxt.newdat;
        res_msglst <= ram_wr_en && obj_nxt.msglst;
        res_intpnd <= ram_wr_en && obj_nxt.intpnd;
        res_txrqst <= ram_wr_en && obj_nxt.txrqst;
      end
    end
  end
endmodule

// File: rtl/acf_filter_chk.sv
module acf_filter_chk
  import acf_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int AW      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic             hdr_ready,
  input logic             ram_rd_en,
  input logic             ram_wr_en,
  input logic [AW-1:0]    ram_addr,
  input logic [OBJ_W-1:0] ram_wdata,
  input logic [OBJ_W-1:0] ram_rdata,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_newdat,
  input logic             res_msglst,
  input logic             res_intpnd,
  input logic             res_txrqst
);
  obj_t rd_o, wd_o, tx_only;
  always_comb begin
    rd_o = obj_t'(ram_rdata);
    wd_o = obj_t'(ram_wdata);
    tx_only = rd_o;
    tx_only.txrqst = 1'b1;
  end

  assert_ready_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready |=> !hdr_ready);
  assert_no_rd_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |-> !ram_wr_en);
  assert_read_pacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |=> !ram_rd_en && $stable(ram_addr));
  assert_valid_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> rd_o.msgval);
  assert_data_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en && !rd_o.dir |-> wd_o.newdat && !wd_o.txrqst);
  assert_lost_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en && rd_o.msglst |-> wd_o.msglst);
  assert_autoreply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en && rd_o.dir && rd_o.rmten |-> wd_o == tx_only);
  assert_blocked_remote_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en && rd_o.dir && !rd_o.rmten |-> rd_o.umask);
  assert_masked_remote_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en && rd_o.dir && !rd_o.rmten |->
      wd_o.data == rd_o.data && wd_o.newdat && !wd_o.txrqst);
  assert_write_reports_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |=> res_valid && res_hit);
  assert_miss_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> !(res_newdat || res_msglst || res_intpnd || res_txrqst));
  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind acf_filter acf_filter_chk #(.NUM_OBJ(NUM_OBJ), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .ram_addr(ram_addr),
  .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .res_valid(res_valid),
  .res_hit(res_hit), .res_newdat(res_newdat), .res_msglst(res_msglst),
  .res_intpnd(res_intpnd), .res_txrqst(res_txrqst)
);

// File: tb/acf_filter_bench.sv
module acf_filter_bench;
  import acf_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_OBJ    = 32;
  localparam int AW         = $clog2(NUM_OBJ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0, hdr_ready, hdr_ide = 1'b0, hdr_rtr = 1'b0;
  logic [ID_W-1:0] hdr_id = '0;
  logic [DLC_W-1:0] hdr_dlc = '0;
  logic [DATA_W-1:0] hdr_data = '0;
  logic ram_rd_en, ram_wr_en;
  logic [AW-1:0] ram_addr, res_obj;
  logic [OBJ_W-1:0] ram_wdata;
  logic [OBJ_W-1:0] ram_rdata = '0;
  logic res_valid, res_hit, res_newdat, res_msglst, res_intpnd, res_txrqst;

  obj_t mem [NUM_OBJ];
  logic clr = 1'b0, ld_en = 1'b0;
  logic [AW-1:0] ld_idx = '0;
  obj_t ld_obj = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  int got_lat;
  logic got_hit, got_rdy_busy, got_rdy_res, got_nd, got_ml, got_ip, got_tx;
  logic [AW-1:0] got_obj;

  always #(CLK_PERIOD/2) clk = ~clk;

  acf_filter u_acf_filter (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_id(hdr_id), .hdr_ide(hdr_ide), .hdr_rtr(hdr_rtr), .hdr_dlc(hdr_dlc),
    .hdr_data(hdr_data), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .res_valid(res_valid), .res_hit(res_hit), .res_obj(res_obj),
    .res_newdat(res_newdat), .res_msglst(res_msglst), .res_intpnd(res_intpnd),
    .res_txrqst(res_txrqst)
  );

  // RAM model, sole writer of mem
  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < NUM_OBJ; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_idx] <= ld_obj;
    end else if (ram_wr_en) begin
      mem[ram_addr] <= obj_t'(ram_wdata);
    end
    if (ram_rd_en) ram_rdata <= mem[ram_addr];
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [OBJ_W-1:0] act, input logic [OBJ_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic obj_t mk(input logic dir, input logic rmten, input logic umask,
                              input logic mxtd, input logic xtd,
                              input logic [ID_W-1:0] id, input logic [ID_W-1:0] msk);
    obj_t o = '0;
    o.msgval = 1'b1; o.dir = dir; o.rmten = rmten; o.umask = umask;
    o.mxtd = mxtd; o.xtd = xtd; o.id = id; o.msk = msk;
    return o;
  endfunction

  function automatic logic [ID_W-1:0] sid(input logic [10:0] s);
    return {s, 18'h0};
  endfunction

  task automatic clear_all();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic load(input int idx, input obj_t o);
    @(negedge clk); ld_en = 1'b1; ld_idx = AW'(idx); ld_obj = o;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic send(input logic [ID_W-1:0] id, input logic ide, input logic rtr,
                      input logic [DLC_W-1:0] dlc, input logic [DATA_W-1:0] data);
    @(negedge clk);
    hdr_id = id; hdr_ide = ide; hdr_rtr = rtr; hdr_dlc = dlc; hdr_data = data;
    hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    hdr_data = ~data;
    got_rdy_busy = hdr_ready;
    got_lat = 0;
    while (!res_valid && got_lat < 4 * NUM_OBJ) begin
      @(negedge clk);
      got_lat++;
    end
    got_rdy_res = hdr_ready; got_hit = res_hit; got_obj = res_obj;
    got_nd = res_newdat; got_ml = res_msglst; got_ip = res_intpnd; got_tx = res_txrqst;
  endtask

  task automatic t_reset();
    chk("R1", "ready after reset", hdr_ready, 1);
    chk("R12", "no result after reset", res_valid, 0);
    chk("R2", "no RAM access after reset", {ram_rd_en, ram_wr_en}, 0);
  endtask

  task automatic t_data_exact();
    obj_t o, e;
    clear_all();
    o = mk(0, 0, 0, 0, 1, 29'h1234567, '0);
    o.rxie = 1; o.txrqst = 1; o.data = 64'h1111;
    load(3, o);
    send(29'h1234567, 1, 0, 4'd8, 64'h0123456789ABCDEF);
    e = o; e.dlc = 4'd8; e.data = 64'h0123456789ABCDEF;
    e.newdat = 1; e.txrqst = 0; e.intpnd = 1;
    chk("R1", "ready low during scan", got_rdy_busy, 0);
    chk("R1", "ready back with result", got_rdy_res, 1);
    chk("R3", "latency to object 3", got_lat, 8);
    chk("R7", "hit reported", got_hit, 1);
    chk("R12", "object index", got_obj, 3);
    chk("R7", "stored object", mem[3], e);
    chk("R12", "flags", {got_nd, got_ml, got_ip, got_tx}, 4'b1010);
  endtask

  task automatic t_priority();
    obj_t o2, o5, o9;
    clear_all();
    o2 = mk(0, 0, 0, 0, 1, 29'h0000ABC, '0); o2.msgval = 0;
    o5 = mk(0, 0, 1, 0, 0, 29'h1F00000, '0);
    o9 = mk(0, 0, 1, 0, 0, 29'h0000001, '0);
    load(2, o2); load(5, o5); load(9, o9);
    send(29'h0000ABC, 1, 0, 4'd1, 64'h55);
    chk("R4", "lowest valid hit index", got_obj, 5);
    chk("R3", "latency to object 5", got_lat, 12);
    chk("R4", "invalid object untouched", mem[2], o2);
    chk("R4", "later match untouched", mem[9], o9);
  endtask

  task automatic t_mask();
    obj_t o0, o1, e;
    clear_all();
    o0 = mk(0, 0, 1, 1, 1, 29'h0ABCDE00, 29'h1FFFFF00);
    o1 = mk(0, 0, 1, 0, 1, {11'h155, 18'h3FFFF}, '1);
    load(0, o0); load(1, o1);
    send(29'h0ABCDE5A, 1, 0, 4'd2, 64'hAA);
    e = o0; e.id = 29'h0ABCDE5A; e.dlc = 2; e.data = 64'hAA; e.newdat = 1;
    chk("R5", "masked low bits hit obj0", got_obj, 0);
    chk("R7", "received id stored under mask", mem[0], e);
    send(29'h0ABCDF5A, 1, 0, 4'd2, 64'hBB);
    chk("R5", "cared bit differs: miss", got_hit, 0);
    chk("R3", "miss latency", got_lat, 2 * NUM_OBJ);
    chk("R12", "miss index and flags", {got_obj, got_nd, got_ml, got_ip, got_tx}, 0);
    send(sid(11'h155), 0, 0, 4'd3, 64'hCC);
    e = o1; e.id = sid(11'h155); e.xtd = 0; e.dlc = 3; e.data = 64'hCC; e.newdat = 1;
    chk("R5", "extended flag ignored when mask-extended 0", got_obj, 1);
    chk("R6", "standard store zeroes low id", mem[1], e);
  endtask

  task automatic t_standard();
    obj_t o0, o4, e;
    clear_all();
    o0 = mk(0, 0, 0, 0, 1, {11'h2A5, 18'h00001}, '0);
    o4 = mk(0, 0, 0, 0, 0, {11'h2A5, 18'h3C3C3}, '0);
    load(0, o0); load(4, o4);
    send({11'h2A5, 18'h00015}, 0, 0, 4'd4, 64'hDD);
    e = o4; e.id = sid(11'h2A5); e.dlc = 4; e.data = 64'hDD; e.newdat = 1;
    chk("R5", "exact compare rejects format mismatch", mem[0], o0);
    chk("R6", "std compare ignores low bits", got_obj, 4);
    chk("R6", "std store", mem[4], e);
  endtask

  task automatic t_msglst();
    obj_t o, e;
    clear_all();
    o = mk(0, 0, 0, 0, 1, 29'h00000777, '0);
    load(7, o);
    send(29'h00000777, 1, 0, 4'd1, 64'h1);
    chk("R8", "first store no loss", {got_nd, got_ml}, 2'b10);
    send(29'h00000777, 1, 0, 4'd1, 64'h2);
    chk("R8", "second store sets lost", {got_nd, got_ml}, 2'b11);
    o = mem[7]; o.newdat = 0;
    load(7, o);
    send(29'h00000777, 1, 0, 4'd5, 64'h3);
    e = o; e.dlc = 5; e.data = 64'h3; e.newdat = 1;
    chk("R8", "lost stays set", mem[7], e);
  endtask

  task automatic t_remote();
    obj_t o2, o6, o8, o10, e;
    clear_all();
    o6 = mk(1, 1, 0, 0, 0, sid(11'h321), '0); o6.dlc = 2; o6.data = 64'h99;
    load(6, o6);
    send(sid(11'h321), 0, 1, 4'd5, 64'h0);
    e = o6; e.txrqst = 1;
    chk("R9", "auto-reply sets only tx-request", mem[6], e);
    chk("R9", "result flags", {got_nd, got_tx}, 2'b01);
    o2 = mk(1, 0, 0, 0, 0, sid(11'h456), '0); o2.txrqst = 1;
    o8 = mk(1, 1, 0, 0, 0, sid(11'h456), '0);
    load(2, o2); load(8, o8);
    send(sid(11'h456), 0, 1, 4'd0, 64'h0);
    chk("R10", "blocked object skipped", got_obj, 8);
    chk("R10", "blocked object unchanged", mem[2], o2);
    chk("R3", "latency to object 8", got_lat, 18);
    o10 = mk(1, 0, 1, 1, 0, sid(11'h0F0), 29'h1FFC0000);
    o10.txrqst = 1; o10.dlc = 8; o10.data = 64'hFEEDFACE;
    load(10, o10);
    send({11'h0F0, 18'h00007}, 0, 1, 4'd3, 64'h1234);
    e = o10; e.id = sid(11'h0F0); e.dlc = 3; e.newdat = 1; e.txrqst = 0;
    chk("R11", "masked remote store keeps data", mem[10], e);
  endtask

  task automatic t_dir();
    obj_t o;
    clear_all();
    o = mk(0, 0, 1, 0, 0, sid(11'h111), '1);
    load(0, o);
    send(sid(11'h111), 0, 1, 4'd1, 64'h0);
    chk("R5", "direction mismatch misses", got_hit, 0);
    chk("R12", "no write on miss", mem[0], o);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_exact();
    t_priority();
    t_mask();
    t_standard();
    t_msglst();
    t_remote();
    t_dir();
    summary();
  end
endmodule